// File: doc/BRIEF.md
# Event Timestamp Capture Unit

The block timestamps events on two external inputs against a free-running counter that advances once per system clock and wraps silently. Each input is first synchronized to the clock and then passed through a digital noise filter: a new level is only believed after it has been seen on a set number of consecutive clocks. A qualifying transition of the filtered level is a rising or a falling edge, chosen per input, and it counts only while that input is enabled. It writes the counter value, tagged with the number of the input that produced it, into a small first-in first-out queue.

Software drains the queue through a read port that always presents the oldest entry; a read strobe removes it. Empty and full flags report the fill state, a sticky flag records that a capture was lost for lack of room, and an interrupt line requests service while entries are waiting. Both inputs may qualify on the same clock; both entries are then written in that one cycle, in a fixed order.

Top module: `frcCapture`

## Requirements
- R1: After reset the counter starts at 0, advances by one on every clock and wraps from 2^CNT_W-1 to 0 without stopping; stamps are taken modulo 2^CNT_W.
- R2: The stamp stored for an accepted transition equals the counter value at the clock edge that first samples the new input level, plus FILT_LEN+2.
- R3: A new input level is accepted only after it has been sampled on FILT_LEN consecutive clocks; a pulse held for fewer clocks produces no capture, and one held for FILT_LEN clocks or more produces one.
- R4: edgeSel[i]=1 selects the rising edge of input i, edgeSel[i]=0 the falling edge; the other edge produces no entry.
- R5: While evtEn[i]=0, transitions of input i produce no entry.
- R6: Entries leave the queue in the order they were written; rdData and rdSrc show the oldest entry while fifoEmpty=0, rdSrc is 0 for input 0 and 1 for input 1, and rdEn=1 removes that entry; rdEn on an empty queue has no effect.
- R7: When both inputs qualify on the same clock, the input 0 entry is written before the input 1 entry and both carry the same stamp.
- R8: A capture that finds no free entry is dropped (a read in the same clock does not free room for it) and sets ovfFlag; ovfFlag stays 1 until ovfClr=1, and a new drop wins over a clear in the same clock. If one free entry remains and both inputs qualify, the input 0 entry is kept and the input 1 entry dropped.
- R9: fifoEmpty=1 exactly when no entry is held and fifoFull=1 exactly when DEPTH entries are held; after reset fifoEmpty=1, fifoFull=0, ovfFlag=0 and irq=0.
- R10: irq is 1 exactly when intEn=1 and the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter and filters run on it |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 2 | Raw event inputs, asynchronous to clk |
| evtEn | input | 2 | Per-input capture enable |
| edgeSel | input | 2 | Per-input edge choice: 1 rising, 0 falling |
| intEn | input | 1 | Interrupt enable |
| rdEn | input | 1 | Removes the oldest entry when the queue is not empty |
| ovfClr | input | 1 | Clears the sticky overflow flag |
| rdData | output | CNT_W | Stamp of the oldest entry |
| rdSrc | output | 1 | Input number of the oldest entry |
| fifoEmpty | output | 1 | Queue holds no entry |
| fifoFull | output | 1 | Queue holds DEPTH entries |
| ovfFlag | output | 1 | Sticky: a capture was dropped |
| irq | output | 1 | Service request |

## Verification
The bench runs a small build (10-bit counter, four entries, four-clock filter) and sweeps the pulse width from one clock to two beyond the filter length, which separates an off-by-one filter from a correct one because only widths of FILT_LEN and above may leave an entry. Single pulses with each edge choice and with the enable off tell the edge selection and gating apart, and every stamp is compared with an arithmetic model of the counter, so any change in pipeline depth shows as a wrong value. A capture placed just before the counter limit exposes the wrap, and coincident pulses on both inputs, on an empty queue and with one entry left, show write order, shared stamp and partial drop. Filling beyond capacity checks the drop rule, the sticky flag and that the surviving entries keep their order.

// File: rtl/frcCapPkg.sv
package frcCapPkg;

  // Strobes from the control half to the storage half, one clock each.
  typedef struct packed {
    logic accept0;  // write an entry tagged with input 0
    logic accept1;  // write an entry tagged with input 1 (after input 0 if both)
    logic pop;      // retire the oldest entry
  } capStrobeT;

endpackage

// File: rtl/frcEvtFilter.sv
module frcEvtFilter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanLvl
);

  // Two-stage synchronizer for the asynchronous input.
  logic [1:0] syncQ;
  logic       synced;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], rawIn};
  end

  assign synced = syncQ[1];

  generate
    if (FILT_LEN <= 1) begin : gDirect
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cleanLvl <= 1'b0;
        else       cleanLvl <= synced;
      end
    end else begin : gCount
      localparam int RUN_W = $clog2(FILT_LEN);
      logic [RUN_W-1:0] run;

      // Count clocks on which the synchronized level differs from the
      // believed one; any agreeing sample restarts the count.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          run      <= '0;
          cleanLvl <= 1'b0;
        end else if (synced == cleanLvl) begin
          run <= '0;
        end else if (run == RUN_W'(FILT_LEN - 1)) begin
          cleanLvl <= synced;
          run      <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/frcCapCtrl.sv
module frcCapCtrl
  import frcCapPkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cleanLvl,
  input  logic [1:0]       evtEn,
  input  logic [1:0]       edgeSel,
  input  logic             rdEn,
  input  logic             ovfClr,
  input  logic [LVL_W-1:0] fifoLevel,
  output capStrobeT        strobe,
  output logic             ovfFlag
);

  logic [1:0]       hit;
  logic [LVL_W-1:0] room;
  logic             acc0;
  logic             acc1;
  logic             drop;

  generate
    for (genvar i = 0; i < 2; i++) begin : gEdge
      logic prevLvl;
      logic riseNow;
      logic fallNow;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevLvl <= 1'b0;
        else       prevLvl <= cleanLvl[i];
      end

      assign riseNow = cleanLvl[i] & ~prevLvl;
      assign fallNow = ~cleanLvl[i] & prevLvl;
      assign hit[i]  = evtEn[i] & (edgeSel[i] ? riseNow : fallNow);
    end
  endgenerate

  // Room is judged on the level before any same-cycle read.
  always_comb begin
    room = LVL_W'(DEPTH) - fifoLevel;
    acc0 = hit[0] && (room != '0);
    acc1 = hit[1] && (room > LVL_W'(acc0));
    drop = (hit[0] && !acc0) || (hit[1] && !acc1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ovfFlag <= 1'b0;
    else if (drop)   ovfFlag <= 1'b1;
    else if (ovfClr) ovfFlag <= 1'b0;
  end

  assign strobe.accept0 = acc0;
  assign strobe.accept1 = acc1;
  assign strobe.pop     = rdEn && (fifoLevel != '0);

endmodule

// File: rtl/frcCapPath.sv
module frcCapPath
  import frcCapPkg::*;
#(
  parameter  int CNT_W = 26,
  parameter  int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobeT        strobe,
  output logic [CNT_W-1:0] headStamp,
  output logic             headSrc,
  output logic [LVL_W-1:0] level
);

  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] stampMem [DEPTH];
  logic [DEPTH-1:0] srcMem;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] slotB;
  logic [LVL_W-1:0] nPush;
  logic             wrAEn;
  logic             wrASrc;
  logic             wrBEn;

  // Free-running timestamp counter; natural wrap at 2^CNT_W.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) freeCnt <= '0;
    else       freeCnt <= freeCnt + 1'b1;
  end

  always_comb begin
    wrAEn  = strobe.accept0 | strobe.accept1;
    wrASrc = ~strobe.accept0;
    wrBEn  = strobe.accept0 & strobe.accept1;
    slotB  = wrPtr + 1'b1;
    nPush  = LVL_W'(strobe.accept0) + LVL_W'(strobe.accept1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) stampMem[k] <= '0;
      srcMem <= '0;
    end else begin
      if (wrAEn) begin
        stampMem[wrPtr] <= freeCnt;
        srcMem[wrPtr]   <= wrASrc;
      end
      if (wrBEn) begin
        stampMem[slotB] <= freeCnt;
        srcMem[slotB]   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(nPush);
      rdPtr <= rdPtr + PTR_W'(strobe.pop);
      level <= level + nPush - LVL_W'(strobe.pop);
    end
  end

  assign headStamp = stampMem[rdPtr];
  assign headSrc   = srcMem[rdPtr];

endmodule

// File: rtl/frcCapture.sv
module frcCapture
  import frcCapPkg::*;
#(
  parameter  int CNT_W    = 26,
  parameter  int DEPTH    = 8,
  parameter  int FILT_LEN = 8,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       evtIn,
  input  logic [1:0]       evtEn,
  input  logic [1:0]       edgeSel,
  input  logic             intEn,
  input  logic             rdEn,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] rdData,
  output logic             rdSrc,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             ovfFlag,
  output logic             irq
);

  logic [1:0]       cleanLvl;
  logic [LVL_W-1:0] fifoLevel;
  capStrobeT        strobe;

  generate
    for (genvar i = 0; i < 2; i++) begin : gFilt
      frcEvtFilter #(.FILT_LEN(FILT_LEN)) uFilt (
        .clk      (clk),
        .rstN     (rstN),
        .rawIn    (evtIn[i]),
        .cleanLvl (cleanLvl[i])
      );
    end
  endgenerate

  frcCapCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cleanLvl  (cleanLvl),
    .evtEn     (evtEn),
    .edgeSel   (edgeSel),
    .rdEn      (rdEn),
    .ovfClr    (ovfClr),
    .fifoLevel (fifoLevel),
    .strobe    (strobe),
    .ovfFlag   (ovfFlag)
  );

  frcCapPath #(.CNT_W(CNT_W), .DEPTH(DEPTH)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .headStamp (rdData),
    .headSrc   (rdSrc),
    .level     (fifoLevel)
  );

  assign fifoEmpty = (fifoLevel == '0);
  assign fifoFull  = (fifoLevel == LVL_W'(DEPTH));
  assign irq       = intEn & ~fifoEmpty;

endmodule

// File: rtl/frcCaptureChk.sv
module frcCaptureChk (
  input logic clk,
  input logic rstN,
  input logic rdEn,
  input logic ovfClr,
  input logic fifoEmpty,
  input logic fifoFull,
  input logic ovfFlag,
  input logic irq
);

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(!fifoEmpty));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !rdEn) |=> fifoFull);

  // R8
  pop_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && rdEn) |=> !fifoFull);

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEmpty && fifoFull));

  // R10
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !irq);

endmodule

bind frcCapture frcCaptureChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .ovfClr    (ovfClr),
  .fifoEmpty (fifoEmpty),
  .fifoFull  (fifoFull),
  .ovfFlag   (ovfFlag),
  .irq       (irq)
);

// File: tb/tb_frcCapture.sv
`timescale 1ns/1ps
module tb_frcCapture;

  localparam int TW  = 10;
  localparam int TD  = 4;
  localparam int TF  = 4;
  localparam int MOD = 1 << TW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    evtIn = '0;
  logic [1:0]    evtEn = '0;
  logic [1:0]    edgeSel = '0;
  logic          intEn = 1'b0;
  logic          rdEn = 1'b0;
  logic          ovfClr = 1'b0;
  logic [TW-1:0] rdData;
  logic          rdSrc;
  logic          fifoEmpty;
  logic          fifoFull;
  logic          ovfFlag;
  logic          irq;

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  longint mdl = 0;

  always #2.5 clk = ~clk;

  // Arithmetic model of the free-running counter (R1).
  always @(posedge clk or negedge rstN) begin
    if (!rstN) mdl <= 0;
    else       mdl <= mdl + 1;
  end

  frcCapture #(.CNT_W(TW), .DEPTH(TD), .FILT_LEN(TF)) dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .evtEn(evtEn), .edgeSel(edgeSel),
    .intEn(intEn), .rdEn(rdEn), .ovfClr(ovfClr), .rdData(rdData), .rdSrc(rdSrc),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic longint stampNow();
    return (mdl + TF + 2) % MOD;
  endfunction

  // Drive a pulse on one input, starting at a falling clock edge.
  task automatic pulse(input int ch, input int w, output longint sRise, output longint sFall);
    sRise = stampNow();
    evtIn[ch] = 1'b1;
    waitCyc(w);
    sFall = stampNow();
    evtIn[ch] = 1'b0;
    waitCyc(TF + 6);
  endtask

  task automatic readChk(input string tag, input longint expStamp, input int expSrc);
    chk(fifoEmpty == 1'b0, {tag, " notEmpty"}, fifoEmpty, 0);
    chk(rdData == TW'(expStamp), {tag, " stamp"}, rdData, expStamp);
    chk(rdSrc == expSrc[0], {tag, " src"}, rdSrc, expSrc);
    rdEn = 1'b1;
    waitCyc(1);
    rdEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    longint sr, sf, sv;
    longint st [8];
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R9: reset state
    chk(fifoEmpty == 1'b1, "R9 reset empty", fifoEmpty, 1);
    chk(fifoFull == 1'b0, "R9 reset full", fifoFull, 0);
    chk(ovfFlag == 1'b0, "R9 reset ovf", ovfFlag, 0);
    chk(irq == 1'b0, "R10 reset irq", irq, 0);

    // R6: read on empty queue has no effect
    rdEn = 1'b1; waitCyc(1); rdEn = 1'b0; waitCyc(1);
    chk(fifoEmpty == 1'b1, "R6 read on empty", fifoEmpty, 1);

    // R3 / R2: width sweep on input 0, rising edge
    evtEn = 2'b11; edgeSel = 2'b11;
    for (int w = 1; w <= TF + 2; w++) begin
      pulse(0, w, sr, sf);
      if (w >= TF) readChk($sformatf("R3 R2 width=%0d", w), sr, 0);
      chk(fifoEmpty == 1'b1, $sformatf("R3 single entry width=%0d", w), fifoEmpty, 1);
    end

    // R4: falling edge on input 1
    edgeSel = 2'b01;
    pulse(1, TF + 3, sr, sf);
    readChk("R4 falling stamp", sf, 1);
    chk(fifoEmpty == 1'b1, "R4 rising edge ignored", fifoEmpty, 1);
    edgeSel = 2'b11;

    // R5: disabled input
    evtEn = 2'b10;
    pulse(0, TF + 3, sr, sf);
    chk(fifoEmpty == 1'b1, "R5 disabled input", fifoEmpty, 1);
    evtEn = 2'b11;

    // R7: coincident transitions on an empty queue
    sv = stampNow();
    evtIn = 2'b11; waitCyc(TF + 3); evtIn = 2'b00; waitCyc(TF + 6);
    readChk("R7 first", sv, 0);
    readChk("R7 second", sv, 1);

    // R10: interrupt gating
    pulse(0, TF + 1, sr, sf);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    intEn = 1'b1; waitCyc(1);
    chk(irq == 1'b1, "R10 irq pending", irq, 1);
    readChk("R10 entry", sr, 0);
    chk(irq == 1'b0, "R10 irq after drain", irq, 0);
    intEn = 1'b0;

    // R1: counter wrap
    while ((mdl % MOD) != MOD - 4) waitCyc(1);
    pulse(0, TF + 1, sr, sf);
    chk(sr < MOD - 4, "R1 wrap model", sr, (MOD - 4 + TF + 2) % MOD);
    readChk("R1 wrapped stamp", sr, 0);

    // R8: overflow on a full queue, order of survivors
    for (int k = 0; k <= TD; k++) pulse(0, TF + 1, st[k], sf);
    chk(fifoFull == 1'b1, "R9 full", fifoFull, 1);
    chk(ovfFlag == 1'b1, "R8 overflow set", ovfFlag, 1);
    for (int k = 0; k < TD; k++) readChk($sformatf("R8 R6 order %0d", k), st[k], 0);
    chk(fifoEmpty == 1'b1, "R8 dropped entry absent", fifoEmpty, 1);
    chk(ovfFlag == 1'b1, "R8 overflow sticky", ovfFlag, 1);
    ovfClr = 1'b1; waitCyc(1); ovfClr = 1'b0; waitCyc(1);
    chk(ovfFlag == 1'b0, "R8 overflow cleared", ovfFlag, 0);

    // R8 / R7: one free entry, both inputs qualify
    for (int k = 0; k < TD - 1; k++) pulse(0, TF + 1, st[k], sf);
    sv = stampNow();
    evtIn = 2'b11; waitCyc(TF + 3); evtIn = 2'b00; waitCyc(TF + 6);
    chk(ovfFlag == 1'b1, "R8 partial drop flag", ovfFlag, 1);
    chk(fifoFull == 1'b1, "R8 partial drop full", fifoFull, 1);
    for (int k = 0; k < TD - 1; k++) readChk($sformatf("R8 fill %0d", k), st[k], 0);
    readChk("R8 R7 input0 kept", sv, 0);
    chk(fifoEmpty == 1'b1, "R8 input1 dropped", fifoEmpty, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule